// File: doc/BRIEF.md
# Subnormal Operand Screening Stage

This stage sits in front of a single-precision floating-point execution unit. It looks at the one or two operands of each operation and finds any that are subnormal, meaning the exponent field is zero and the fraction is not. A single enable input chooses what happens next. With trapping on, the operands pass through unchanged. The write of the operation's result into the floating-point register file is gated off, and a cause flag and a one-cycle exception event are raised. With trapping off, each subnormal operand is replaced by a zero of the same sign before the arithmetic sees it, the write goes ahead, and a sticky accrued flag records that a flush happened.

Operand screening is purely combinational. The flags are registered, and they change only when an operation is actually handed on. The data path is a valid/ready stream with no storage. `in_ready` follows `out_ready`, and `out_valid` follows `in_valid`. A transfer happens in any cycle where `in_valid` and `out_ready` are both high. While `out_ready` is low the producer must hold its operands, and no flag changes. The write gate `wr_en` qualifies the transfer for the register file.

Top module: `fp_subnormal_screen`

## Requirements
- R1: An examined operand is subnormal exactly when bits 30:23 are all zero and bits 22:0 are not. Signed zeros, normal numbers, infinities and NaNs are never subnormal.
- R2: With `trap_en`=1, `wr_en` is low in any cycle where an examined operand is subnormal. The screened operands then equal the inputs bit for bit.
- R3: With `trap_en`=1, a transfer carrying one or more subnormal operands sets `cause_flag` in the next cycle. It also raises `exc_event` for exactly one cycle, even when both operands are subnormal.
- R4: With `trap_en`=0, each examined subnormal operand is output with bit 31 kept and bits 30:0 cleared. `wr_en` then equals `out_valid`.
- R5: With `trap_en`=0, a transfer carrying a subnormal operand sets `accrued_flag` in the next cycle. It leaves `cause_flag` at 0 and `exc_event` low.
- R6: `accrued_flag` stays set through later clean transfers until `clr_accrued` is high at a clock edge. If a clear and a new flush meet at the same edge, the flag ends up set.
- R7: `cause_flag` is rewritten on every transfer, so a clean transfer clears it.
- R8: With `op_b_used`=0, operand B is not examined. `scr_b` equals `op_b`, and B raises no flag and does not gate `wr_en`.
- R9: `out_valid` equals `in_valid` and `in_ready` equals `out_ready`. The flags and `exc_event` change only on a transfer (`in_valid` and `out_ready` both high), apart from the clear in R6.
- R10: After reset, `cause_flag`, `accrued_flag` and `exc_event` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operands present |
| in_ready | output | 1 | Stage can take operands |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_b_used | input | 1 | Operation reads operand B |
| trap_en | input | 1 | 1: trap on subnormal, 0: flush to zero |
| clr_accrued | input | 1 | Clears the accrued flag |
| out_valid | output | 1 | Screened operands present |
| out_ready | input | 1 | Execution unit takes operands |
| scr_a | output | 32 | Screened operand A |
| scr_b | output | 32 | Screened operand B |
| wr_en | output | 1 | Register-file write permitted for this operation |
| cause_flag | output | 1 | Last transfer trapped on a subnormal |
| accrued_flag | output | 1 | Sticky record of a flush |
| exc_event | output | 1 | One-cycle exception pulse |

## Verification
The assertions watch every cycle for the following. The write gate must be closed whenever trapping meets a subnormal and must track `out_valid` when trapping is off. A flushed operand must keep its sign and have its magnitude cleared. The handshake must stay a wire. The cause flag must be rewritten on each transfer, and the accrued flag must only drop when a clear asks for it. Other behaviour needs the directed scenarios to show it. These cover the boundary encodings that separate zero, subnormal and special values, the single event when both operands are subnormal, and the unused second operand being left alone. They also cover the clear colliding with a new flush, and the flags holding still while `out_ready` is low.

// File: rtl/fps_pkg.sv
package fps_pkg;
  localparam int unsigned EXP_W  = 8;
  localparam int unsigned FRAC_W = 23;
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W;
  localparam int unsigned N_OPS  = 2;

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  exp;
    logic [FRAC_W-1:0] frac;
  } fp_word_t;

  typedef enum logic [1:0] {
    CLS_ZERO    = 2'd0,
    CLS_SUB     = 2'd1,
    CLS_NORM    = 2'd2,
    CLS_SPECIAL = 2'd3
  } fp_class_e;
endpackage

// File: rtl/fps_classify.sv
module fps_classify
  import fps_pkg::*;
(
  input  fp_word_t word,
  input  logic     examine,
  output logic     is_sub
);
  fp_class_e cls;
  logic exp_zero, exp_ones, frac_zero;

  always_comb begin
    exp_zero  = (word.exp == '0);
    exp_ones  = (word.exp == '1);
    frac_zero = (word.frac == '0);
    if (exp_zero && frac_zero)      cls = CLS_ZERO;
    else if (exp_zero)              cls = CLS_SUB;
    else if (exp_ones)              cls = CLS_SPECIAL;
    else                            cls = CLS_NORM;
    is_sub = examine && (cls == CLS_SUB);
  end
endmodule

// File: rtl/fps_flush.sv
module fps_flush
  import fps_pkg::*;
(
  input  fp_word_t word_in,
  input  logic     flush,
  output fp_word_t word_out
);
  always_comb begin
    word_out = word_in;
    if (flush) begin
      word_out.exp  = '0;
      word_out.frac = '0;
    end
  end
endmodule

// File: rtl/fps_flag_unit.sv
module fps_flag_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic trap_en,
  input  logic any_sub,
  input  logic clr_accrued,
  output logic cause_flag,
  output logic accrued_flag,
  output logic exc_event
);
  logic trap_hit, flush_hit;

  always_comb begin
    trap_hit  = accept && any_sub && trap_en;
    flush_hit = accept && any_sub && !trap_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_flag   <= 1'b0;
      accrued_flag <= 1'b0;
      exc_event    <= 1'b0;
    end else begin
      if (accept) cause_flag <= trap_hit;
      accrued_flag <= (accrued_flag && !clr_accrued) || flush_hit;
      exc_event    <= trap_hit;
    end
  end
endmodule

// File: rtl/fp_subnormal_screen.sv
module fp_subnormal_screen
  import fps_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  input  logic              op_b_used,
  input  logic              trap_en,
  input  logic              clr_accrued,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] scr_a,
  output logic [WORD_W-1:0] scr_b,
  output logic              wr_en,
  output logic              cause_flag,
  output logic              accrued_flag,
  output logic              exc_event
);
  fp_word_t        lane_in  [N_OPS];
  fp_word_t        lane_out [N_OPS];
  logic [N_OPS-1:0] lane_exam;
  logic [N_OPS-1:0] lane_sub;
  logic            any_sub;
  logic            accept;

  always_comb begin
    lane_in[0]   = fp_word_t'(op_a);
    lane_in[1]   = fp_word_t'(op_b);
    lane_exam[0] = 1'b1;
    lane_exam[1] = op_b_used;
  end

  for (genvar i = 0; i < N_OPS; i++) begin : g_lane
    fps_classify u_cls (
      .word    (lane_in[i]),
      .examine (lane_exam[i]),
      .is_sub  (lane_sub[i])
    );
    fps_flush u_fl (
      .word_in  (lane_in[i]),
      .flush    (lane_sub[i] && !trap_en),
      .word_out (lane_out[i])
    );
  end

  always_comb begin
    any_sub   = |lane_sub;
    in_ready  = out_ready;
    out_valid = in_valid;
    accept    = in_valid && out_ready;
    scr_a     = lane_out[0];
    scr_b     = lane_out[1];
    wr_en     = in_valid && !(trap_en && any_sub);
  end

  fps_flag_unit u_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (accept),
    .trap_en      (trap_en),
    .any_sub      (any_sub),
    .clr_accrued  (clr_accrued),
    .cause_flag   (cause_flag),
    .accrued_flag (accrued_flag),
    .exc_event    (exc_event)
  );
endmodule

// File: rtl/fps_screen_checker.sv
module fps_screen_checker
  import fps_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [WORD_W-1:0] op_a,
  input logic [WORD_W-1:0] op_b,
  input logic              op_b_used,
  input logic              trap_en,
  input logic              clr_accrued,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] scr_a,
  input logic [WORD_W-1:0] scr_b,
  input logic              wr_en,
  input logic              cause_flag,
  input logic              accrued_flag,
  input logic              exc_event
);
  logic sub_a, sub_b, sub_any, xfer;
  always_comb begin
    sub_a   = (op_a[WORD_W-2 -: EXP_W] == '0) && (op_a[FRAC_W-1:0] != '0);
    sub_b   = op_b_used && (op_b[WORD_W-2 -: EXP_W] == '0) && (op_b[FRAC_W-1:0] != '0);
    sub_any = sub_a || sub_b;
    xfer    = in_valid && out_ready;
  end

  assert_trap_blocks_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_en && sub_any) |-> (!wr_en && scr_a == op_a && scr_b == op_b));

  assert_event_sets_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    exc_event |-> cause_flag);

  assert_flush_keeps_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_en && sub_a) |-> (scr_a[WORD_W-1] == op_a[WORD_W-1] && scr_a[WORD_W-2:0] == '0));

  assert_flush_writes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_en |-> (wr_en == out_valid));

  assert_accrued_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accrued_flag && !clr_accrued) |=> accrued_flag);

  assert_cause_rewritten_R7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (cause_flag == $past(trap_en && sub_any)));

  assert_b_unused_passes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !op_b_used |-> (scr_b == op_b));

  assert_handshake_wire_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready == out_ready) && (out_valid == in_valid));

  assert_no_xfer_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> ($stable(cause_flag) && !exc_event));
endmodule

bind fp_subnormal_screen fps_screen_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .op_a(op_a), .op_b(op_b), .op_b_used(op_b_used), .trap_en(trap_en),
  .clr_accrued(clr_accrued), .out_valid(out_valid), .out_ready(out_ready),
  .scr_a(scr_a), .scr_b(scr_b), .wr_en(wr_en), .cause_flag(cause_flag),
  .accrued_flag(accrued_flag), .exc_event(exc_event)
);

// File: tb/fp_subnormal_screen_bench.sv
module fp_subnormal_screen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1, op_b_used = 1'b1, trap_en = 1'b0, clr_accrued = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic in_ready, out_valid, wr_en, cause_flag, accrued_flag, exc_event;
  logic [31:0] scr_a, scr_b;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fp_subnormal_screen u_fp_subnormal_screen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .op_b_used(op_b_used), .trap_en(trap_en),
    .clr_accrued(clr_accrued), .out_valid(out_valid), .out_ready(out_ready),
    .scr_a(scr_a), .scr_b(scr_b), .wr_en(wr_en), .cause_flag(cause_flag),
    .accrued_flag(accrued_flag), .exc_event(exc_event)
  );

  localparam logic [31:0] SUB_POS = 32'h0000_0001;
  localparam logic [31:0] SUB_NEG = 32'h807F_FFFF;
  localparam logic [31:0] NORM1   = 32'h3F80_0000;
  localparam logic [31:0] NORM2   = 32'hC040_0000;
  localparam logic [31:0] MINNORM = 32'h0080_0000;
  localparam logic [31:0] INF     = 32'h7F80_0000;
  localparam logic [31:0] NAN     = 32'h7FC0_0001;
  localparam logic [31:0] NZERO   = 32'h8000_0000;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic present(input logic [31:0] a, input logic [31:0] b, input logic bu, input logic tr);
    @(negedge clk);
    op_a = a; op_b = b; op_b_used = bu; trap_en = tr; in_valid = 1'b1;
    #1;
  endtask

  task automatic finish_xfer;
    @(negedge clk);
    in_valid = 1'b0; clr_accrued = 1'b0;
    #1;
  endtask

  task automatic clear_flags;
    present(NORM1, NORM2, 1'b1, 1'b0);
    clr_accrued = 1'b1;
    finish_xfer();
  endtask

  task automatic t_reset;
    chk("R10 cause", {31'b0, cause_flag}, 32'd0);
    chk("R10 accrued", {31'b0, accrued_flag}, 32'd0);
    chk("R10 event", {31'b0, exc_event}, 32'd0);
  endtask

  task automatic t_normal;
    present(NORM1, NORM2, 1'b1, 1'b1);
    chk("R1 normal a pass", scr_a, NORM1);
    chk("R1 normal b pass", scr_b, NORM2);
    chk("R1 normal wr_en", {31'b0, wr_en}, 32'd1);
    finish_xfer();
    chk("R7 normal cause", {31'b0, cause_flag}, 32'd0);
  endtask

  task automatic t_boundaries;
    present(NZERO, MINNORM, 1'b1, 1'b1);
    chk("R1 neg zero wr_en", {31'b0, wr_en}, 32'd1);
    finish_xfer();
    present(INF, NAN, 1'b1, 1'b1);
    chk("R1 inf nan wr_en", {31'b0, wr_en}, 32'd1);
    chk("R1 nan pass", scr_b, NAN);
    finish_xfer();
    chk("R1 boundary cause", {31'b0, cause_flag}, 32'd0);
  endtask

  task automatic t_flush;
    present(SUB_POS, SUB_NEG, 1'b1, 1'b0);
    chk("R4 flush a", scr_a, 32'h0000_0000);
    chk("R4 flush b signed", scr_b, NZERO);
    chk("R4 flush wr_en", {31'b0, wr_en}, 32'd1);
    finish_xfer();
    chk("R5 accrued set", {31'b0, accrued_flag}, 32'd1);
    chk("R5 cause clear", {31'b0, cause_flag}, 32'd0);
    chk("R5 no event", {31'b0, exc_event}, 32'd0);
  endtask

  task automatic t_sticky_clear;
    present(NORM1, NORM2, 1'b1, 1'b0);
    finish_xfer();
    chk("R6 sticky", {31'b0, accrued_flag}, 32'd1);
    @(negedge clk); clr_accrued = 1'b1;
    @(negedge clk); clr_accrued = 1'b0; #1;
    chk("R6 cleared", {31'b0, accrued_flag}, 32'd0);
    present(SUB_NEG, NORM1, 1'b1, 1'b0);
    clr_accrued = 1'b1;
    finish_xfer();
    chk("R6 set beats clear", {31'b0, accrued_flag}, 32'd1);
  endtask

  task automatic t_trap;
    clear_flags();
    present(SUB_NEG, NORM2, 1'b1, 1'b1);
    chk("R2 trap wr_en", {31'b0, wr_en}, 32'd0);
    chk("R2 trap a unchanged", scr_a, SUB_NEG);
    finish_xfer();
    chk("R3 cause set", {31'b0, cause_flag}, 32'd1);
    chk("R3 event", {31'b0, exc_event}, 32'd1);
    chk("R3 accrued untouched", {31'b0, accrued_flag}, 32'd0);
    present(NORM1, NORM2, 1'b1, 1'b1);
    finish_xfer();
    chk("R7 cause rewritten", {31'b0, cause_flag}, 32'd0);
  endtask

  task automatic t_both;
    present(SUB_POS, SUB_NEG, 1'b1, 1'b1);
    chk("R2 both wr_en", {31'b0, wr_en}, 32'd0);
    finish_xfer();
    chk("R3 both event", {31'b0, exc_event}, 32'd1);
    @(negedge clk); #1;
    chk("R3 single pulse", {31'b0, exc_event}, 32'd0);
    chk("R3 cause held", {31'b0, cause_flag}, 32'd1);
  endtask

  task automatic t_b_unused;
    clear_flags();
    present(NORM1, SUB_NEG, 1'b0, 1'b1);
    chk("R8 b unused wr_en", {31'b0, wr_en}, 32'd1);
    chk("R8 b unused pass", scr_b, SUB_NEG);
    finish_xfer();
    chk("R8 b unused cause", {31'b0, cause_flag}, 32'd0);
    present(NORM1, SUB_POS, 1'b0, 1'b0);
    chk("R8 b no flush", scr_b, SUB_POS);
    finish_xfer();
    chk("R8 b no accrued", {31'b0, accrued_flag}, 32'd0);
  endtask

  task automatic t_stall;
    out_ready = 1'b0;
    present(SUB_POS, NORM1, 1'b1, 1'b1);
    chk("R9 ready follows", {31'b0, in_ready}, 32'd0);
    chk("R9 valid follows", {31'b0, out_valid}, 32'd1);
    @(negedge clk); #1;
    chk("R9 stall cause", {31'b0, cause_flag}, 32'd0);
    chk("R9 stall event", {31'b0, exc_event}, 32'd0);
    trap_en = 1'b0;
    @(negedge clk); #1;
    chk("R9 stall accrued", {31'b0, accrued_flag}, 32'd0);
    in_valid = 1'b0; out_ready = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_normal();
    t_boundaries();
    t_flush();
    t_sticky_clear();
    t_trap();
    t_both();
    t_b_unused();
    t_stall();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule